// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node end of a directory coherence scheme for a small multiprocessor whose nodes talk over a routed network rather than a snooped bus. For every memory block it owns, the controller keeps one of three states (Uncached, Shared, Exclusive), a bit-vector naming every node that holds a read copy, and the index of the single node that holds a writable copy. Requests from node caches arrive on one channel. The controller answers them by sending data or permission, invalidating other copies and pulling dirty data back from an owner. It reads and writes the backing memory through a plain memory port.

Only one transaction is open at a time. While invalidations are awaiting acknowledgement, or an owner is being asked for its data, the request channel is held back. Competing requests are therefore ordered purely by the order in which the controller accepts them. The memory port has a combinational read (data for `mem_addr` is valid in the same cycle) and a write on the clock edge when `mem_we` is high.

Top module: `dirco_home`

## Requirements
- R1: After reset every block is Uncached, `req_ready` is 1, and no message or memory write is produced until a request is accepted.
- R2: A read request (kind 0) to an Uncached block is answered with a DATA message (kind 0) carrying the memory contents, sent to the requester one cycle after acceptance. The block becomes Shared with the requester as its only sharer.
- R3: A write request (kind 1) or an upgrade request (kind 2) to an Uncached block is answered with DATA from memory, and the block becomes Exclusive with the requester as owner.
- R4: A read request to a Shared block is answered with DATA from memory and adds the requester to the sharers. Any later write by another node must invalidate it.
- R5: An upgrade from a node that is a current sharer of a Shared block sends one invalidation message (kind 2) to every other sharer, at most one per cycle in ascending node order. It then sends GRANT (kind 1, data 0) to the requester, and the block becomes Exclusive owned by the requester.
- R6: The reply to a write or upgrade that caused invalidations is not sent until as many acknowledgement responses (response kind 0) have arrived as invalidations were sent.
- R7: A write request, or an upgrade from a node that is not a sharer, to a Shared block invalidates every sharer other than the requester and is answered with DATA from memory. No invalidation is ever addressed to the requester.
- R8: While invalidations or owner data are outstanding, `req_ready` is 0 and no request is accepted. A request held during that time is accepted after the open transaction completes.
- R9: A read request to an Exclusive block from a non-owner sends a FETCH message (kind 3) to the owner. When that owner returns a data response (response kind 1), the data is written to memory and sent as DATA to the requester, and the block becomes Shared with both nodes as sharers.
- R10: A write request to an Exclusive block from a non-owner fetches the owner's data the same way, writes it to memory and sends it as DATA to the requester. The requester becomes the owner and the block stays Exclusive.
- R11: A writeback request (kind 3) from the owner of an Exclusive block writes its data to memory and makes the block Uncached, with no message. A writeback from any other node changes neither memory nor directory state and sends no message.
- R12: A read, write or upgrade request from the current owner of an Exclusive block is answered with GRANT and leaves the directory state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 writeback |
| req_node | input | NW | Requesting node |
| req_blk | input | AW | Block index |
| req_data | input | DW | Writeback data |
| msg_valid | output | 1 | Outgoing message present for one cycle |
| msg_kind | output | 2 | 0 DATA, 1 GRANT, 2 INV, 3 FETCH |
| msg_node | output | NW | Destination node |
| msg_blk | output | AW | Block index |
| msg_data | output | DW | Data for DATA messages, else 0 |
| rsp_valid | input | 1 | Response from a node present |
| rsp_kind | input | 1 | 0 acknowledgement, 1 owner data |
| rsp_node | input | NW | Responding node |
| rsp_data | input | DW | Owner data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory block address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data for mem_addr |

## Verification
The bench builds the controller with four nodes, four blocks and 16-bit data. Four nodes let one write face three sharers at once, so the acknowledgement counter runs through a full multi-step countdown. The extra blocks show that an owner of one block does not disturb another block's state. Withholding acknowledgements from the bench's node model shows the reply is held and the request channel is closed. The node model's distinct data values trace where the data went through fetches, writebacks and ignored writebacks.

// File: rtl/dirco_pkg.sv
package dirco_pkg;
    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_INVAL = 2'd1,
        FSM_FETCH = 2'd2
    } fsm_e;

    localparam logic [1:0] REQ_READ    = 2'd0;
    localparam logic [1:0] REQ_WRITE   = 2'd1;
    localparam logic [1:0] REQ_UPGRADE = 2'd2;
    localparam logic [1:0] REQ_WRBACK  = 2'd3;

    localparam logic [1:0] MSG_DATA  = 2'd0;
    localparam logic [1:0] MSG_GRANT = 2'd1;
    localparam logic [1:0] MSG_INV   = 2'd2;
    localparam logic [1:0] MSG_FETCH = 2'd3;

    localparam logic RSP_ACK  = 1'b0;
    localparam logic RSP_DATA = 1'b1;
endpackage

// File: rtl/dirco_table.sv
module dirco_table #(
    parameter int BLOCKS = 4,
    parameter int EW     = 8,
    localparam int AW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [EW-1:0] rd_ent,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_ent
);
    logic [EW-1:0] rows [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_row
        logic [EW-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_addr == AW'(b)) begin
                ent_d = wr_ent;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign rows[b] = ent_q;
    end

    assign rd_ent = rows[rd_addr];
endmodule

// File: rtl/dirco_lowbit.sv
module dirco_lowbit #(
    parameter int NODES = 4,
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [NODES-1:0] vec,
    output logic [NW-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = NW'(i);
            end
        end
    end
endmodule

// File: rtl/dirco_popcnt.sv
module dirco_popcnt #(
    parameter int NODES = 4,
    localparam int CW   = $clog2(NODES + 1)
) (
    input  logic [NODES-1:0] vec,
    output logic [CW-1:0]    count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NODES; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/dirco_home.sv
module dirco_home
    import dirco_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int DW     = 16,
    localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int AW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [NW-1:0] req_node,
    input  logic [AW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [NW-1:0] msg_node,
    output logic [AW-1:0] msg_blk,
    output logic [DW-1:0] msg_data,
    input  logic          rsp_valid,
    input  logic          rsp_kind,
    input  logic [NW-1:0] rsp_node,
    input  logic [DW-1:0] rsp_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int CW = $clog2(NODES + 1);
    localparam int EW = 2 + NODES + NW;

    typedef struct packed {
        blk_state_e       st;
        logic [NODES-1:0] shr;
        logic [NW-1:0]    own;
    } ent_t;

    typedef struct packed {
        fsm_e             fsm;
        logic [1:0]       kind;
        logic [NW-1:0]    src;
        logic [AW-1:0]    blk;
        logic [NODES-1:0] mask;
        logic [CW-1:0]    cnt;
        logic             use_grant;
        logic             mv;
        logic [1:0]       mk;
        logic [NW-1:0]    mn;
        logic [AW-1:0]    mb;
        logic [DW-1:0]    md;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [AW-1:0]    rd_addr;
    logic [EW-1:0]    rd_raw;
    ent_t             cur;
    logic             tab_we;
    logic [AW-1:0]    tab_wa;
    ent_t             tab_wd;
    logic [NODES-1:0] others;
    logic [CW-1:0]    oth_cnt;
    logic [NW-1:0]    inv_idx;
    logic [CW-1:0]    cnt_after;
    logic             ack_in;
    logic             grant_now;

    // Aliases used by the bound checker
    logic [NW-1:0]    src_q;
    logic [AW-1:0]    blk_q;
    logic [CW-1:0]    cnt_q;
    logic             inval_q;

    assign rd_addr = (s_q.fsm == FSM_IDLE) ? req_blk : s_q.blk;
    assign cur     = ent_t'(rd_raw);
    assign others  = cur.shr & ~(NODES'(1) << req_node);
    assign ack_in  = rsp_valid && (rsp_kind == RSP_ACK);

    dirco_table #(.BLOCKS(BLOCKS), .EW(EW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_ent  (rd_raw),
        .wr_en   (tab_we),
        .wr_addr (tab_wa),
        .wr_ent  (tab_wd)
    );

    dirco_popcnt #(.NODES(NODES)) u_count (
        .vec   (others),
        .count (oth_cnt)
    );

    dirco_lowbit #(.NODES(NODES)) u_pick (
        .vec (s_q.mask),
        .idx (inv_idx)
    );

    always_comb begin
        s_d       = s_q;
        s_d.mv    = 1'b0;
        s_d.mk    = MSG_DATA;
        s_d.md    = '0;
        tab_we    = 1'b0;
        tab_wa    = s_q.blk;
        tab_wd    = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        grant_now = 1'b0;
        cnt_after = s_q.cnt - CW'(ack_in && (s_q.cnt != '0));

        unique case (s_q.fsm)
            FSM_IDLE: begin
                if (req_valid) begin
                    s_d.kind = req_kind;
                    s_d.src  = req_node;
                    s_d.blk  = req_blk;
                    s_d.mn   = req_node;
                    s_d.mb   = req_blk;
                    tab_wa   = req_blk;
                    if (req_kind == REQ_WRBACK) begin
                        if (cur.st == BLK_EXC && cur.own == req_node) begin
                            mem_we    = 1'b1;
                            mem_wdata = req_data;
                            tab_we    = 1'b1;
                            tab_wd.st = BLK_UNC;
                        end
                    end else if (cur.st == BLK_EXC) begin
                        s_d.mv = 1'b1;
                        if (cur.own == req_node) begin
                            s_d.mk = MSG_GRANT;
                        end else begin
                            s_d.mk  = MSG_FETCH;
                            s_d.mn  = cur.own;
                            s_d.fsm = FSM_FETCH;
                        end
                    end else if (req_kind == REQ_READ) begin
                        s_d.mv     = 1'b1;
                        s_d.md     = mem_rdata;
                        tab_we     = 1'b1;
                        tab_wd.st  = BLK_SHR;
                        tab_wd.shr = cur.shr | (NODES'(1) << req_node);
                    end else begin
                        grant_now = (req_kind == REQ_UPGRADE) && (cur.st == BLK_SHR)
                                    && cur.shr[req_node];
                        s_d.use_grant = grant_now;
                        if (others != '0) begin
                            s_d.mask = others;
                            s_d.cnt  = oth_cnt;
                            s_d.fsm  = FSM_INVAL;
                        end else begin
                            s_d.mv     = 1'b1;
                            s_d.mk     = grant_now ? MSG_GRANT : MSG_DATA;
                            s_d.md     = grant_now ? '0 : mem_rdata;
                            tab_we     = 1'b1;
                            tab_wd.st  = BLK_EXC;
                            tab_wd.own = req_node;
                        end
                    end
                end
            end
            FSM_INVAL: begin
                s_d.cnt = cnt_after;
                if (s_q.mask != '0) begin
                    s_d.mv   = 1'b1;
                    s_d.mk   = MSG_INV;
                    s_d.mn   = inv_idx;
                    s_d.mb   = s_q.blk;
                    s_d.mask = s_q.mask & ~(NODES'(1) << inv_idx);
                end else if (cnt_after == '0) begin
                    s_d.mv     = 1'b1;
                    s_d.mk     = s_q.use_grant ? MSG_GRANT : MSG_DATA;
                    s_d.md     = s_q.use_grant ? '0 : mem_rdata;
                    s_d.mn     = s_q.src;
                    s_d.mb     = s_q.blk;
                    tab_we     = 1'b1;
                    tab_wd.st  = BLK_EXC;
                    tab_wd.own = s_q.src;
                    s_d.fsm    = FSM_IDLE;
                end
            end
            FSM_FETCH: begin
                if (rsp_valid && rsp_kind == RSP_DATA && rsp_node == cur.own) begin
                    mem_we    = 1'b1;
                    mem_wdata = rsp_data;
                    s_d.mv    = 1'b1;
                    s_d.mk    = MSG_DATA;
                    s_d.md    = rsp_data;
                    s_d.mn    = s_q.src;
                    s_d.mb    = s_q.blk;
                    tab_we    = 1'b1;
                    if (s_q.kind == REQ_READ) begin
                        tab_wd.st  = BLK_SHR;
                        tab_wd.shr = (NODES'(1) << cur.own) | (NODES'(1) << s_q.src);
                    end else begin
                        tab_wd.st  = BLK_EXC;
                        tab_wd.own = s_q.src;
                    end
                    s_d.fsm = FSM_IDLE;
                end
            end
            default: s_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.fsm == FSM_IDLE);
    assign msg_valid = s_q.mv;
    assign msg_kind  = s_q.mk;
    assign msg_node  = s_q.mn;
    assign msg_blk   = s_q.mb;
    assign msg_data  = s_q.md;
    assign mem_addr  = rd_addr;

    assign src_q   = s_q.src;
    assign blk_q   = s_q.blk;
    assign cnt_q   = s_q.cnt;
    assign inval_q = (s_q.fsm == FSM_INVAL);
endmodule

// File: rtl/dirco_home_chk.sv
module dirco_home_chk
    import dirco_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int AW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int CW    = $clog2(NODES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          msg_valid,
    input logic [1:0]    msg_kind,
    input logic [NW-1:0] msg_node,
    input logic          rsp_valid,
    input logic          rsp_kind,
    input logic [NW-1:0] src_q,
    input logic [AW-1:0] blk_q,
    input logic [CW-1:0] cnt_q,
    input logic          inval_q
);
    // R8
    inv_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> !req_ready);

    // R7
    inv_not_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INV) |-> (msg_node != src_q));

    // R6
    reply_waits_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_q && cnt_q != '0 && !(rsp_valid && rsp_kind == RSP_ACK))
        |=> !(msg_valid && (msg_kind == MSG_DATA || msg_kind == MSG_GRANT)));

    // R8
    open_block_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready || $stable(blk_q)));

    // R6
    always @(posedge clk) begin
        if (rst_n) begin
            ack_count_bound_chk: assert (cnt_q <= CW'(NODES - 1));
        end
    end
endmodule

bind dirco_home dirco_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .msg_node  (msg_node),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .src_q     (src_q),
    .blk_q     (blk_q),
    .cnt_q     (cnt_q),
    .inval_q   (inval_q)
);

// File: tb/tb_dirco_home.sv
module tb_dirco_home;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4;
    localparam int BLOCKS = 4;
    localparam int DW = 16;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  node;
        logic [1:0]  blk;
        logic [15:0] wdata;
        logic        exp_reply;
        logic [1:0]  exp_kind;
        logic [15:0] exp_data;
        logic [2:0]  exp_inv;
        logic        exp_fetch;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 2'd0, 2'd1, 16'h0000, 1'b1, 2'd0, 16'h1001, 3'd0, 1'b0}, // R2
        '{2'd0, 2'd1, 2'd1, 16'h0000, 1'b1, 2'd0, 16'h1001, 3'd0, 1'b0}, // R4
        '{2'd2, 2'd1, 2'd1, 16'hA1A1, 1'b1, 2'd1, 16'h0000, 3'd1, 1'b0}, // R5 R6
        '{2'd1, 2'd2, 2'd1, 16'hB2B2, 1'b1, 2'd0, 16'hA1A1, 3'd0, 1'b1}, // R10
        '{2'd0, 2'd3, 2'd1, 16'h0000, 1'b1, 2'd0, 16'hB2B2, 3'd0, 1'b1}, // R9
        '{2'd0, 2'd0, 2'd1, 16'h0000, 1'b1, 2'd0, 16'hB2B2, 3'd0, 1'b0}, // R4 R9 memory written
        '{2'd1, 2'd1, 2'd1, 16'hC3C3, 1'b1, 2'd0, 16'hB2B2, 3'd3, 1'b0}, // R7
        '{2'd3, 2'd1, 2'd1, 16'hC3C3, 1'b0, 2'd0, 16'h0000, 3'd0, 1'b0}, // R11 owner writeback
        '{2'd0, 2'd2, 2'd1, 16'h0000, 1'b1, 2'd0, 16'hC3C3, 3'd0, 1'b0}, // R11 R2 after writeback
        '{2'd2, 2'd3, 2'd1, 16'hD4D4, 1'b1, 2'd0, 16'hC3C3, 3'd1, 1'b0}, // R7 upgrade from non-sharer
        '{2'd2, 2'd1, 2'd2, 16'h5555, 1'b1, 2'd0, 16'h1002, 3'd0, 1'b0}, // R3 upgrade to Uncached
        '{2'd3, 2'd0, 2'd1, 16'hEEEE, 1'b0, 2'd0, 16'h0000, 3'd0, 1'b0}, // R11 non-owner ignored
        '{2'd0, 2'd0, 2'd1, 16'h0000, 1'b1, 2'd0, 16'hD4D4, 3'd0, 1'b1}, // R9 R11 still owned
        '{2'd1, 2'd0, 2'd0, 16'h6666, 1'b1, 2'd0, 16'h1000, 3'd0, 1'b0}  // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_node = '0;
    logic [1:0]    req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          msg_valid;
    logic [1:0]    msg_kind;
    logic [1:0]    msg_node;
    logic [1:0]    msg_blk;
    logic [DW-1:0] msg_data;
    logic          rsp_valid = 1'b0;
    logic          rsp_kind = 1'b0;
    logic [1:0]    rsp_node = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          mem_we;
    logic [1:0]    mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] mem [BLOCKS];
    logic [DW-1:0] node_val [NODES];
    int tests = 0;
    int fails = 0;
    int inv_cnt = 0;
    int fetch_cnt = 0;
    int reply_seen = 0;
    int ack_pend = 0;
    int fetch_pend = 0;
    int fetch_node = 0;
    bit ack_en = 1'b1;
    bit done = 1'b0;
    logic [1:0]    rep_node [64];
    logic [1:0]    rep_kind [64];
    logic [DW-1:0] rep_data [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dirco_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_blk(msg_blk), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
        .rsp_data(rsp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Network and node model: log messages, answer INV and FETCH
    always @(negedge clk) begin
        if (msg_valid) begin
            case (msg_kind)
                2'd2: ack_pend++;
                2'd3: begin fetch_pend = 1; fetch_node = int'(msg_node); fetch_cnt++; end
                default: begin
                    rep_node[reply_seen % 64] = msg_node;
                    rep_kind[reply_seen % 64] = msg_kind;
                    rep_data[reply_seen % 64] = msg_data;
                    reply_seen++;
                end
            endcase
            if (msg_kind == 2'd2) inv_cnt++;
        end
        rsp_valid = 1'b0;
        rsp_kind  = 1'b0;
        rsp_node  = '0;
        rsp_data  = '0;
        if (ack_en && ack_pend > 0) begin
            rsp_valid = 1'b1;
            ack_pend--;
        end else if (fetch_pend != 0) begin
            rsp_valid = 1'b1;
            rsp_kind  = 1'b1;
            rsp_node  = 2'(fetch_node);
            rsp_data  = node_val[fetch_node];
            fetch_pend = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] k, input logic [1:0] n,
                            input logic [1:0] b, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_node  = n;
        req_blk   = b;
        req_data  = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_reply(input int target);
        int t = 0;
        while (reply_seen < target && t < 60) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        for (int b = 0; b < BLOCKS; b++) mem[b] = 16'h1000 + 16'(b);
        for (int n = 0; n < NODES; n++) node_val[n] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 no message in reset", 32'(msg_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no message after reset", 32'(msg_valid), 32'd0);
        chk("R1 no memory write after reset", 32'(mem_we), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            int r0, i0, f0;
            r0 = reply_seen;
            i0 = inv_cnt;
            f0 = fetch_cnt;
            send_req(VEC[i].kind, VEC[i].node, VEC[i].blk, VEC[i].wdata);
            if (VEC[i].exp_reply) begin
                wait_reply(r0 + 1);
                chk($sformatf("vector %0d reply count", i), 32'(reply_seen - r0), 32'd1);
                chk($sformatf("vector %0d reply node", i), 32'(rep_node[r0 % 64]), 32'(VEC[i].node));
                chk($sformatf("vector %0d reply kind", i), 32'(rep_kind[r0 % 64]), 32'(VEC[i].exp_kind));
                chk($sformatf("vector %0d reply data", i), 32'(rep_data[r0 % 64]), 32'(VEC[i].exp_data));
                if (VEC[i].kind == 2'd1 || VEC[i].kind == 2'd2) node_val[VEC[i].node] = VEC[i].wdata;
            end
            repeat (4) @(negedge clk);
            if (!VEC[i].exp_reply)
                chk($sformatf("vector %0d no reply", i), 32'(reply_seen - r0), 32'd0);
            chk($sformatf("vector %0d invalidations", i), 32'(inv_cnt - i0), 32'(VEC[i].exp_inv));
            chk($sformatf("vector %0d fetches", i), 32'(fetch_cnt - f0), 32'(VEC[i].exp_fetch));
        end

        // R4: three readers of block 3
        for (int n = 0; n < 3; n++) begin
            int r0;
            r0 = reply_seen;
            send_req(2'd0, 2'(n), 2'd3, '0);
            wait_reply(r0 + 1);
            chk("R4 shared read data", 32'(rep_data[r0 % 64]), 32'h1003);
        end

        // R6 R8: withheld acknowledgements hold the reply and the request channel
        begin
            int r0, i0;
            r0 = reply_seen;
            i0 = inv_cnt;
            ack_en = 1'b0;
            send_req(2'd1, 2'd3, 2'd3, '0);
            repeat (8) @(negedge clk);
            chk("R6 no reply before acks", 32'(reply_seen - r0), 32'd0);
            chk("R7 three invalidations", 32'(inv_cnt - i0), 32'd3);
            chk("R8 ready low while waiting", 32'(req_ready), 32'd0);
            req_valid = 1'b1;
            req_kind  = 2'd0;
            req_node  = 2'd0;
            req_blk   = 2'd0;
            repeat (3) @(negedge clk);
            chk("R8 held request not accepted", 32'(req_ready), 32'd0);
            chk("R8 no reply while held", 32'(reply_seen - r0), 32'd0);
            ack_en = 1'b1;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            wait_reply(r0 + 2);
            chk("R6 write reply node", 32'(rep_node[r0 % 64]), 32'd3);
            chk("R6 write reply data", 32'(rep_data[r0 % 64]), 32'h1003);
            chk("R8 held request served second", 32'(rep_node[(r0 + 1) % 64]), 32'd0);
            chk("R12 owner read gets GRANT", 32'(rep_kind[(r0 + 1) % 64]), 32'd1);
            node_val[3] = 16'h7777;
        end

        // R11: owner writeback then read from memory
        begin
            int r0;
            r0 = reply_seen;
            send_req(2'd3, 2'd3, 2'd3, 16'h7777);
            repeat (3) @(negedge clk);
            chk("R11 writeback sends nothing", 32'(reply_seen - r0), 32'd0);
            chk("R11 memory updated", 32'(mem[3]), 32'h7777);
            send_req(2'd0, 2'd1, 2'd3, '0);
            wait_reply(r0 + 1);
            chk("R11 read after writeback", 32'(rep_data[r0 % 64]), 32'h7777);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule